// File: doc/BRIEF.md
# Paged GPIO Edge-Interrupt Controller

This block watches a set of general-purpose input lines, arranged as several byte-wide ports. Each line is first brought into the local clock domain, then checked for an edge of a direction chosen bit by bit. A matching edge on an enabled line latches a pending flag. A single interrupt output goes high while any enabled line has a pending flag.

A host reaches the block through a plain byte-wide register bus. The last offset holds a page register, and its two top bits choose which bank appears at the port offsets. The banks are input data, edge direction, enable and pending. Writes take effect on the clock edge on which the write strobe is high. Reads are combinational from the address.

The bus has no handshake. Every access completes in one cycle, so the host never sees back-pressure. A write to the pending bank clears a whole port, whatever data is written. Disabling a line drops its pending flag.

Top module: `gei_paged_irq`

## Requirements
- R1: After reset the page register reads 0x00, every direction, enable and pending bit is 0, and `irq_o` is 0.
- R2: Offset 3 is the page register. It reads back the whole written byte. Bits 7:6 select the page: 00 data, 01 direction, 10 enable, 11 pending. Bits 5:0 are plain storage.
- R3: With page 00, a read of offset p (p = 0..2) returns port p's inputs after a two-flop synchroniser. Writes to offsets 0..2 on page 00 change no register.
- R4: With page 01, offsets 0..2 read and write the direction bits. A 1 selects rising-edge detection and a 0 selects falling-edge detection.
- R5: With page 10, offsets 0..2 read and write the enable bits.
- R6: An edge of the selected direction sets the pending bit only while the enable bit is 1. An input change driven before clock edge 1 is first readable as pending after clock edge 3.
- R7: On page 11, any write to offset p clears all pending bits of port p, whatever data is written. Other ports are unaffected.
- R8: Writing 0 to an enable bit clears that bit's pending flag. Re-enabling the bit does not restore the flag.
- R9: When a new edge on a bit occurs in the same cycle as a clear of that bit, the bit ends up pending.
- R10: `irq_o` is a register holding the OR over all bits of (pending AND enable). It rises one clock after the pending bit that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_i | input | 24 | Input lines; port p uses bits [8p+7:8p] |
| bus_addr | input | 2 | Register offset (0..2 ports, 3 page register) |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` on the current page |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong page register shows up on the next bus read: the wrong bank, or a cleared storage bit, appears at once at `bus_rdata`. A stuck or wrongly set pending or enable bit is visible one clock later, because `irq_o` is registered. Edge-detector faults appear three clocks after an input change, as a pending value that differs from the one predicted from the direction bits and the old and new input bytes. Clear-rule faults appear on the first pending read after the write that should have cleared the port.

// File: rtl/gei_pkg.sv
package gei_pkg;
  typedef enum logic [1:0] {
    PG_DATA = 2'b00,
    PG_DIR  = 2'b01,
    PG_EN   = 2'b10,
    PG_PEND = 2'b11
  } page_e;

  localparam int PAGE_FIELD_W = 2;
endpackage

// File: rtl/gei_sync.sv
module gei_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gei_edge_port.sv
module gei_edge_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_i,
  input  logic         wr_dir,
  input  logic         wr_en,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] dir_q, en_q, pend_q, prev_q;
  logic [W-1:0] rise, fall, hit, set, drop, pend_d;

  assign rise   = line_i & ~prev_q;
  assign fall   = ~line_i & prev_q;
  assign hit    = (dir_q & rise) | (~dir_q & fall);
  assign set    = hit & en_q;
  assign drop   = (wr_clr ? {W{1'b1}} : '0) | (wr_en ? ~wdata : '0);
  assign pend_d = set | (pend_q & ~drop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      en_q   <= '0;
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= line_i;
      pend_q <= pend_d;
      if (wr_dir) dir_q <= wdata;
      if (wr_en)  en_q  <= wdata;
    end
  end

  assign dir_o  = dir_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;

  // R6: a bit newly pending must have been enabled in the cycle before
  a_r6_set_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

  // R7: a clear with no coinciding edge empties the port
  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wr_en && set == '0) |=> (pend_q == '0));

  // R8: a disabled bit loses its flag unless a new edge set it
  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((pend_q & ~$past(wdata) & ~$past(set)) == '0));

  // R9: a detected enabled edge always lands in the pending register
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((pend_q & $past(set)) == $past(set)));
endmodule

// File: rtl/gei_paged_irq.sv
module gei_paged_irq
  import gei_pkg::*;
#(
  parameter int NPORT = 3,
  parameter int PW    = 8,
  parameter int AW    = $clog2(NPORT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT*PW-1:0] gpio_i,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_wr,
  input  logic [PW-1:0]       bus_wdata,
  output logic [PW-1:0]       bus_rdata,
  output logic                irq_o
);
  localparam logic [AW-1:0] PAGE_ADDR = AW'(NPORT);
  localparam int            TOTAL     = NPORT * PW;

  logic [PW-1:0]    page_q;
  page_e            page_sel;
  logic [TOTAL-1:0] sync_all, dir_all, en_all, pend_all;
  logic             irq_q;

  assign page_sel = page_e'(page_q[PW-1 -: PAGE_FIELD_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               page_q <= '0;
    else if (bus_wr && bus_addr == PAGE_ADDR) page_q <= bus_wdata;
  end

  gei_sync #(.W(TOTAL), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (gpio_i),
    .q    (sync_all)
  );

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic sel;
      assign sel = bus_wr && (bus_addr == AW'(p));
      gei_edge_port #(.W(PW)) u_port (
        .clk   (clk),
        .rst_n (rst_n),
        .line_i(sync_all[p*PW +: PW]),
        .wr_dir(sel && page_sel == PG_DIR),
        .wr_en (sel && page_sel == PG_EN),
        .wr_clr(sel && page_sel == PG_PEND),
        .wdata (bus_wdata),
        .dir_o (dir_all[p*PW +: PW]),
        .en_o  (en_all[p*PW +: PW]),
        .pend_o(pend_all[p*PW +: PW])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == PAGE_ADDR) begin
      bus_rdata = page_q;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (bus_addr == AW'(p)) begin
          unique case (page_sel)
            PG_DATA: bus_rdata = sync_all[p*PW +: PW];
            PG_DIR:  bus_rdata = dir_all[p*PW +: PW];
            PG_EN:   bus_rdata = en_all[p*PW +: PW];
            PG_PEND: bus_rdata = pend_all[p*PW +: PW];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(pend_all & en_all);
  end
  assign irq_o = irq_q;

  // R2: the page register holds exactly the byte last written to it
  a_r2_page_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PAGE_ADDR) |=> (page_q == $past(bus_wdata)));

  // R3: writes on the data page leave direction and enable untouched
  a_r3_data_page_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != PAGE_ADDR && page_sel == PG_DATA)
      |=> ($stable(dir_all) && $stable(en_all)));

  // R10: the request follows the port state one clock later
  a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(pend_all & en_all))));
endmodule

// File: tb/gei_paged_irq_bench.sv
module gei_paged_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] gpio = '0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gei_paged_irq u_gei_paged_irq (
    .clk(clk), .rst_n(rst_n), .gpio_i(gpio), .bus_addr(addr),
    .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  // {direction, old input, new input} for port 0
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {8'hFF, 8'h00, 8'hFF}, {8'h00, 8'hFF, 8'h00},
    {8'hFF, 8'hFF, 8'h00}, {8'h00, 8'h00, 8'hFF},
    {8'hF0, 8'h0F, 8'hF0}, {8'h0F, 8'h0F, 8'hF0},
    {8'hAA, 8'h55, 8'hAA}, {8'h3C, 8'h00, 8'h3C}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_page(input logic [1:0] p);
    bus_write(2'd3, {p, 6'b0});
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] expv;
    idle(3);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    bus_read(2'd3, v);  check("R1 page", v, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    set_page(2'd1); bus_read(2'd0, v); check("R1 dir", v, 8'h00);
    set_page(2'd2); bus_read(2'd1, v); check("R1 en", v, 8'h00);
    set_page(2'd3); bus_read(2'd2, v); check("R1 pend", v, 8'h00);

    // R2 whole byte stored, page from bits 7:6
    bus_write(2'd3, 8'h6B); bus_read(2'd3, v); check("R2 page byte", v, 8'h6B);

    // R4/R5 readback
    bus_write(2'd0, 8'h96); bus_read(2'd0, v); check("R4 dir readback", v, 8'h96);
    set_page(2'd2);
    bus_write(2'd0, 8'hFF); bus_read(2'd0, v); check("R5 en readback", v, 8'hFF);

    // R4/R6 vector table on port 0
    for (int i = 0; i < NV; i++) begin
      logic [7:0] dv, a, b;
      {dv, a, b} = VEC[i];
      set_page(2'd1); bus_write(2'd0, dv);
      @(negedge clk) gpio[7:0] = a;
      idle(4);
      set_page(2'd3); bus_write(2'd0, 8'h5A);
      @(negedge clk) gpio[7:0] = b;
      idle(4);
      bus_read(2'd0, v);
      expv = (dv & ~a & b) | (~dv & a & ~b);
      check($sformatf("R4 R6 vector %0d", i), v, expv);
    end

    // R6/R10 latency on port 1 bit 0
    set_page(2'd1); bus_write(2'd1, 8'h01);
    set_page(2'd2); bus_write(2'd1, 8'h01);
    set_page(2'd3); bus_write(2'd0, 8'h00);
    bus_read(2'd0, v); check("R7 port0 cleared", v, 8'h00);
    idle(2);
    @(negedge clk) addr = 2'd1; gpio[8] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); #1 check("R6 not yet after 2 edges", rdata, 8'h00);
    @(posedge clk);
    @(negedge clk); #1 check("R6 pending after 3 edges", rdata, 8'h01);
    check("R10 irq not yet", {7'b0, irq}, 8'h00);
    @(posedge clk);
    @(negedge clk); #1 check("R10 irq one clock later", {7'b0, irq}, 8'h01);

    // port 0 pending 3C for later tests
    set_page(2'd1); bus_write(2'd0, 8'hFF);
    @(negedge clk) gpio[7:0] = 8'h00; idle(4);
    @(negedge clk) gpio[7:0] = 8'h3C; idle(4);

    // R8 disable clears, re-enable does not restore
    set_page(2'd2); bus_write(2'd0, 8'hF7);
    set_page(2'd3); bus_read(2'd0, v); check("R8 disable clears", v, 8'h34);
    set_page(2'd2); bus_write(2'd0, 8'hFF);
    set_page(2'd3); bus_read(2'd0, v); check("R8 re-enable keeps clear", v, 8'h34);

    // R7 clear one port only
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, v); check("R7 port1 cleared", v, 8'h00);
    bus_read(2'd0, v); check("R7 port0 untouched", v, 8'h34);

    // R9 set wins over clear on port 1
    set_page(2'd1); bus_write(2'd1, 8'h03);
    set_page(2'd2); bus_write(2'd1, 8'h03);
    set_page(2'd3);
    @(negedge clk) gpio[9] = 1'b1; idle(4);
    @(negedge clk) gpio[8] = 1'b0; idle(4);
    bus_read(2'd1, v); check("R9 setup", v, 8'h02);
    @(negedge clk) gpio[8] = 1'b1;
    @(posedge clk); @(posedge clk);
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, v); check("R9 set wins", v, 8'h01);

    // R6 disabled port 2 ignores edges; R3 data reads and inert writes
    @(negedge clk) gpio[23:16] = 8'hA5; idle(4);
    @(negedge clk) gpio[23:16] = 8'h5A; idle(4);
    bus_read(2'd2, v); check("R6 disabled no pending", v, 8'h00);
    set_page(2'd0);
    bus_read(2'd2, v); check("R3 data read", v, 8'h5A);
    bus_write(2'd2, 8'hFF); bus_write(2'd0, 8'h00);
    bus_read(2'd2, v); check("R3 write ignored", v, 8'h5A);
    set_page(2'd1); bus_read(2'd0, v); check("R3 dir unchanged", v, 8'hFF);
    set_page(2'd2); bus_read(2'd0, v); check("R3 en unchanged", v, 8'hFF);

    // R10 irq drops once all pending are cleared
    check("R10 irq high", {7'b0, irq}, 8'h01);
    set_page(2'd3); bus_write(2'd0, 8'h00); bus_write(2'd1, 8'h00);
    idle(2);
    @(negedge clk); check("R10 irq low", {7'b0, irq}, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule